// File: doc/BRIEF.md
# Audio FSK Bit Recovery with Digital PLL

This block turns a stream of signed 8-bit audio samples carrying 1200/2200 Hz frequency-shift keyed data into recovered data bits. Audio arrives at 9600 samples per second, so one 1200-baud symbol covers eight samples. Each sample is multiplied by the sample taken half a symbol earlier. The product is smoothed by a first-order recursive low-pass filter built only from shifts and adds, and the sign of the filter output gives one hard decision per sample.

A small digital phase-locked loop follows these per-sample decisions. It nudges its phase counter toward the transitions it sees. Each time the counter wraps, a 2-of-3 vote over the newest per-sample decisions yields a line bit. The line bit is then NRZI-decoded, so the output is 1 when the line level held and 0 when it changed.

The input `smp_valid` marks each audio sample. Cycles without it leave every piece of state untouched. Each recovered bit is presented on `bit_data` together with a one-cycle `bit_valid` pulse. HDLC deframing is left to the next block.

Top module: `fsk_bit_recover`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bit_valid` and `bit_data` are 0. Reset clears the filter state, the phase counter (to 0) and both decision histories.
- R2: The delay line holds the four previous accepted samples. It is zero after reset, so the correlator product is zero for the first four samples after reset.
- R3: For each accepted sample, the new filter input x1 is (four-samples-old sample × current sample) shifted right arithmetically by 2. The previous x1 is kept as x0.
- R4: With `filt_mode` = 0 the filter computes y = x0 + x1 + (y'>>>1) + (y'>>>3) + (y'>>>5). With `filt_mode` = 1 it computes y = x0 + x1 + (y'>>>1). Here y' is the previous output, and all terms are 16-bit signed with wrap-around.
- R5: The per-sample decision is 1 only when y is strictly greater than 0; y = 0 gives 0.
- R6: When the newest two per-sample decisions differ, the phase is first raised by 1 if it is below 32, or lowered by 1 otherwise. Every accepted sample then adds 8, and the phase always stays below 64.
- R7: When the phase reaches 64 or more it is reduced by 64 and one bit is decided. `bit_valid` is high for exactly the one cycle following that sample's clock edge.
- R8: The decided line bit is 1 when at least two of the three newest per-sample decisions, including the current one, are 1.
- R9: `bit_data` is 1 when the decided line bit equals the previous decided line bit and 0 when it differs. The line-bit history starts at 0 after reset.
- R10: A cycle with `smp_valid` low changes no state: the delay line, filter, phase and histories all hold, and it produces no `bit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | An audio sample is present this cycle |
| smp_data | input | 8 | Signed two's-complement audio sample |
| filt_mode | input | 1 | Filter feedback: 0 three-term, 1 single-term |
| bit_valid | output | 1 | One-cycle strobe for a recovered bit |
| bit_data | output | 1 | NRZI-decoded recovered bit |

## Verification
The assertions assume that `filt_mode` does not change in the middle of a stream. They also assume that `smp_valid` is held low during reset, so that no phase wrap is seen while the loop is being cleared. The bench drives `smp_valid` low throughout each reset and only changes `filt_mode` between scenarios, each of which starts from a fresh reset. Idle cycles with arbitrary `smp_data` are interleaved within one scenario to show that the sample strobe alone gates all state.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic {
    FILT_TRIPLE = 1'b0,
    FILT_SINGLE = 1'b1
  } filt_mode_e;

  // two-of-three vote
  function automatic logic vote3(input logic [2:0] b);
    return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
  endfunction

  // NRZI: held level gives 1, a change gives 0
  function automatic logic nrzi_bit(input logic cur, input logic prev);
    return ~(cur ^ prev);
  endfunction

endpackage

// File: rtl/fbr_correlator.sv
module fbr_correlator #(
  parameter int SAMPLE_W  = 8,
  parameter int ACC_W     = 16,
  parameter int DLY_DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       filt_mode,
  output logic                       slice_bit
);
  import fbr_pkg::*;

  localparam int PROD_W = 2 * SAMPLE_W;

  filt_mode_e mode_e;
  assign mode_e = filt_mode_e'(filt_mode);

  // delay line, oldest at the top index
  logic signed [SAMPLE_W-1:0] dly_q [DLY_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) dly_q[0] <= '0;
    else if (smp_valid) dly_q[0] <= smp_data;
  end

  for (genvar i = 1; i < DLY_DEPTH; i++) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) dly_q[i] <= '0;
      else if (smp_valid) dly_q[i] <= dly_q[i-1];
    end
  end

  function automatic logic signed [ACC_W-1:0] mix(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b
  );
    logic signed [PROD_W-1:0] p;
    logic signed [ACC_W-1:0]  w;
    p = a * b;
    w = p;
    return w >>> 2;
  endfunction

  function automatic logic signed [ACC_W-1:0] feedback(
    input logic signed [ACC_W-1:0] y,
    input filt_mode_e              m
  );
    if (m == FILT_SINGLE) return y >>> 1;
    return (y >>> 1) + (y >>> 3) + (y >>> 5);
  endfunction

  logic signed [ACC_W-1:0] x1_q, y_q;
  logic signed [ACC_W-1:0] x1_next, y_next;

  always_comb begin
    x1_next = mix(dly_q[DLY_DEPTH-1], smp_data);
    y_next  = x1_q + x1_next + feedback(y_q, mode_e);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1_q <= '0;
      y_q  <= '0;
    end else if (smp_valid) begin
      x1_q <= x1_next;
      y_q  <= y_next;
    end
  end

  assign slice_bit = !y_next[ACC_W-1] && (y_next != '0);

endmodule

// File: rtl/fbr_dpll.sv
module fbr_dpll #(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int PHASE_BIT       = 8,
  parameter int PHASE_W         = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic               slice_bit,
  output logic               edge_seen,
  output logic               bit_tick,
  output logic [2:0]         hist3,
  output logic [PHASE_W-1:0] phase_q
);
  localparam int PHASE_MAX  = SAMPLES_PER_BIT * PHASE_BIT;
  localparam int PHASE_HALF = PHASE_MAX / 2;

  logic [1:0] sh_q;

  // newest decision at bit 0
  assign hist3     = {sh_q, slice_bit};
  assign edge_seen = smp_valid && (slice_bit ^ sh_q[0]);

  function automatic logic [PHASE_W-1:0] advance(
    input logic [PHASE_W-1:0] ph,
    input logic               nudge
  );
    logic [PHASE_W-1:0] p;
    p = ph;
    if (nudge) begin
      if (ph < PHASE_W'(PHASE_HALF)) p = ph + 1'b1;
      else                           p = ph - 1'b1;
    end
    return p + PHASE_W'(PHASE_BIT);
  endfunction

  logic [PHASE_W-1:0] ph_raw;
  assign ph_raw   = advance(phase_q, edge_seen);
  assign bit_tick = smp_valid && (ph_raw >= PHASE_W'(PHASE_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      sh_q    <= '0;
    end else if (smp_valid) begin
      sh_q    <= hist3[1:0];
      phase_q <= bit_tick ? ph_raw - PHASE_W'(PHASE_MAX) : ph_raw;
    end
  end

endmodule

// File: rtl/fbr_decider.sv
module fbr_decider (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [2:0] hist3,
  output logic       bit_valid,
  output logic       bit_data
);
  import fbr_pkg::*;

  logic line_prev_q;
  logic line_now;

  assign line_now = vote3(hist3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_prev_q <= 1'b0;
      bit_valid   <= 1'b0;
      bit_data    <= 1'b0;
    end else begin
      bit_valid <= bit_tick;
      if (bit_tick) begin
        line_prev_q <= line_now;
        bit_data    <= nrzi_bit(line_now, line_prev_q);
      end
    end
  end

endmodule

// File: rtl/fsk_bit_recover.sv
module fsk_bit_recover #(
  parameter int SAMPLE_W        = 8,
  parameter int ACC_W           = 16,
  parameter int SAMPLES_PER_BIT = 8,
  parameter int PHASE_BIT       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                filt_mode,
  output logic                bit_valid,
  output logic                bit_data
);
  localparam int DLY_DEPTH = SAMPLES_PER_BIT / 2;
  localparam int PHASE_MAX = SAMPLES_PER_BIT * PHASE_BIT;
  localparam int PHASE_W   = $clog2(PHASE_MAX + PHASE_BIT + 2);

  // internal events, named for the checker
  logic               slice_bit;
  logic               edge_seen;
  logic               bit_tick;
  logic [2:0]         hist3;
  logic [PHASE_W-1:0] phase_q;

  fbr_correlator #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .DLY_DEPTH(DLY_DEPTH)
  ) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .filt_mode(filt_mode),
    .slice_bit(slice_bit)
  );

  fbr_dpll #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .PHASE_BIT      (PHASE_BIT),
    .PHASE_W        (PHASE_W)
  ) u_dpll (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .slice_bit(slice_bit),
    .edge_seen(edge_seen),
    .bit_tick (bit_tick),
    .hist3    (hist3),
    .phase_q  (phase_q)
  );

  fbr_decider u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .hist3    (hist3),
    .bit_valid(bit_valid),
    .bit_data (bit_data)
  );

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int PHASE_W   = 7,
  parameter int PHASE_MAX = 64,
  parameter int PHASE_BIT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_valid,
  input logic               edge_seen,
  input logic               bit_tick,
  input logic [PHASE_W-1:0] phase_q,
  input logic               bit_valid
);
  logic [PHASE_W-1:0] plain_sum;
  logic [PHASE_W-1:0] plain_next;
  assign plain_sum  = phase_q + PHASE_W'(PHASE_BIT);
  assign plain_next = (plain_sum >= PHASE_W'(PHASE_MAX)) ?
                      plain_sum - PHASE_W'(PHASE_MAX) : plain_sum;

  p_phase_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PHASE_W'(PHASE_MAX));

  p_edge_needs_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |-> smp_valid);

  p_plain_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !edge_seen) |=> phase_q == $past(plain_next));

  p_valid_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> bit_valid);

  p_valid_only_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> !bit_valid);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  p_tick_needs_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> smp_valid);

  p_idle_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(phase_q));

endmodule

bind fsk_bit_recover fbr_checker #(
  .PHASE_W  (7),
  .PHASE_MAX(64),
  .PHASE_BIT(8)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .edge_seen(edge_seen),
  .bit_tick (bit_tick),
  .phase_q  (phase_q),
  .bit_valid(bit_valid)
);

// File: tb/fsk_bit_recover_test.sv
module fsk_bit_recover_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic       filt_mode = 1'b0;
  logic       bit_valid, bit_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fsk_bit_recover uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .filt_mode(filt_mode), .bit_valid(bit_valid), .bit_data(bit_data)
  );

  // reference model state
  int m_dly[$];
  int m_x1, m_y, m_hist, m_phase, m_line;
  int bits_seen;

  function automatic int wrap16(input int v);
    int r;
    r = v & 32'h0000FFFF;
    if (r >= 32768) r = r - 65536;
    return r;
  endfunction

  function automatic int fdiv(input int v, input int d);
    // floor division for the arithmetic shifts
    int q;
    q = v / d;
    if ((v % d != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  task automatic model_clear();
    m_dly = '{0, 0, 0, 0};
    m_x1 = 0; m_y = 0; m_hist = 0; m_phase = 0; m_line = 0;
  endtask

  // returns expected valid and data for this sample
  task automatic model_step(input int s, output bit ev, output bit ed);
    int old_s, x1n, fb, nb, ones;
    old_s = m_dly.pop_front();
    m_dly.push_back(s);
    x1n = fdiv(old_s * s, 4);
    if (filt_mode) fb = fdiv(m_y, 2);
    else fb = fdiv(m_y, 2) + fdiv(m_y, 8) + fdiv(m_y, 32);
    m_y = wrap16(m_x1 + x1n + fb);
    m_x1 = x1n;
    nb = (m_y > 0) ? 1 : 0;
    m_hist = ((m_hist << 1) | nb) & 7;
    if (((m_hist >> 1) & 1) != nb) begin
      if (m_phase < 32) m_phase++; else m_phase--;
    end
    m_phase += 8;
    ev = 0; ed = 0;
    if (m_phase >= 64) begin
      m_phase -= 64;
      ones = (m_hist & 1) + ((m_hist >> 1) & 1) + ((m_hist >> 2) & 1);
      ev = 1;
      ed = ((ones >= 2 ? 1 : 0) == m_line);
      m_line = (ones >= 2) ? 1 : 0;
    end
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; filt_mode = mode;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", bit_valid, 1'b0);
    chk("R1 data in reset", bit_data, 1'b0);
    rst_n = 1'b1;
    model_clear();
  endtask

  // one sample (or idle cycle) with checks at the ports
  task automatic push(input string tag, input bit v, input int s);
    bit ev, ed;
    @(negedge clk);
    smp_valid = v;
    smp_data = 8'(s);
    ev = 0; ed = 0;
    if (v) model_step(s, ev, ed);
    @(posedge clk);
    #1;
    chk(tag, bit_valid, ev);
    if (ev) begin
      chk(tag, bit_data, ed);
      bits_seen++;
    end
  endtask

  // keyed tone: NRZI line toggles on data 0
  task automatic send_tones(input string tag, input int nbits, input int ampl,
                            input bit rand_data, input bit gaps);
    real ph;
    bit lvl;
    ph = 0.0; lvl = 1;
    for (int b = 0; b < nbits; b++) begin
      bit d;
      d = rand_data ? 1'($urandom) : 1'b1;
      if (!d) lvl = ~lvl;
      for (int k = 0; k < 8; k++) begin
        ph = ph + (lvl ? 3.14159265358979 / 4.0 : 3.14159265358979 * 2200.0 / 4800.0);
        push(tag, 1'b1, $rtoi(ampl * $sin(ph)));
        if (gaps && (k == 3)) push("R10 idle", 1'b0, int'($urandom) & 255);
      end
    end
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    @(negedge clk);
    chk("R1 valid after reset", bit_valid, 1'b0);
    chk("R1 data after reset", bit_data, 1'b0);
  endtask

  task automatic t_silence();
    do_reset(1'b0);
    bits_seen = 0;
    for (int i = 0; i < 40; i++) begin
      push("R5 zero input", 1'b1, 0);
      if (bit_valid) chk("R9 steady line gives 1", bit_data, 1'b1);
    end
    checks++;
    if (bits_seen != 5) begin
      errors++;
      $display("FAIL R7 bit count got %0d expected 5", bits_seen);
    end
  endtask

  task automatic t_startup();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) push("R2 zero delay line", 1'b1, 127);
    for (int i = 0; i < 40; i++) push("R3 product path", 1'b1, (i % 3 == 0) ? -128 : 127);
  endtask

  task automatic t_mark_triple();
    do_reset(1'b0);
    send_tones("R4 three-term filter", 30, 100, 1'b0, 1'b0);
  endtask

  task automatic t_random_single();
    do_reset(1'b1);
    send_tones("R4 single-term filter", 60, 110, 1'b1, 1'b0);
  endtask

  task automatic t_random_triple();
    do_reset(1'b0);
    send_tones("R8 majority vote", 60, 127, 1'b1, 1'b0);
  endtask

  task automatic t_gaps();
    do_reset(1'b0);
    send_tones("R6 phase tracking with gaps", 40, 90, 1'b1, 1'b1);
  endtask

  task automatic t_fullscale();
    do_reset(1'b0);
    for (int i = 0; i < 64; i++) push("R4 wrap full scale", 1'b1, ((i / 5) % 2 == 0) ? -128 : 127);
  endtask

  initial begin
    t_reset();
    t_silence();
    t_startup();
    t_mark_triple();
    t_random_single();
    t_random_triple();
    t_gaps();
    t_fullscale();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule